// File: doc/BRIEF.md
# Branch Target Address Unit

This unit works out where instruction fetch resumes after a jump or call in a 16-bit segmented real-mode machine. It takes the current code segment and instruction pointer, the length of the branch instruction, a branch kind, an immediate field and a register value. It returns the new code segment, the new instruction pointer and the 20-bit physical fetch address formed from them.

Five branch kinds are handled:

- **Far pointer:** loads both segment and offset from the immediate.
- **Short relative:** adds a signed 8-bit displacement to the address of the following instruction.
- **Near relative:** adds a 16-bit displacement to that same address.
- **Register target:** jumps to the offset held in a register.
- **Memory target:** a double-indirect form that fetches the new offset from data memory. The read goes to the data segment, at the offset held in the register.

Requests enter on a valid/ready channel. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and a held request simply waits while `req_ready` is low.

The memory-target kind drives a one-word read port made of two parts:

- **Address channel:** valid/ready. The address must stay stable while `mem_rd_valid` is high and `mem_rd_ready` is low.
- **Response:** a plain `mem_rsp_valid` strobe with data. It is sampled only after the address handshake has completed, and must arrive at least one cycle after it.

Results are announced by a one-cycle `done` pulse. The result outputs hold their values between pulses.

Top module: `branch_target_unit`

## Requirements
- R1: Kind code 0 (far pointer) loads the new segment from `req_imm[31:16]` and the new offset from `req_imm[15:0]`.
- R2: Kind code 1 (short relative) sets the new offset to `req_ip + req_len + sign-extended req_imm[7:0]`, modulo 2^16, and keeps the segment.
- R3: Kind code 2 (near relative) sets the new offset to `req_ip + req_len + req_imm[15:0]`, modulo 2^16, and keeps the segment.
- R4: Kind code 3 (register target) sets the new offset to `req_reg` and keeps the segment.
- R5: Kind code 4 (memory target) reads the word at physical address `req_ds*16 + req_reg` (20 bits). The returned word becomes the new offset, and the segment is kept.
- R6: `fetch_addr` always equals `new_cs*16 + new_ip`, truncated to 20 bits.
- R7: For kinds other than 4, `done` rises in the cycle after the request is accepted. For kind 4, `done` rises in the cycle after `mem_rsp_valid` is sampled. `req_ready` is low from acceptance of a kind 4 request until its `done`.
- R8: While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request and its address stay unchanged in the next cycle.
- R9: Kind codes 5, 6 and 7 do not branch. They return the same segment and the offset `req_ip + req_len` (modulo 2^16), with `done` in the next cycle.
- R10: After reset, `done` and `mem_rd_valid` are 0, `req_ready` is 1, and `new_cs`, `new_ip` and `fetch_addr` are 0.
- R11: `done` lasts one cycle when no new request follows, and `new_cs`/`new_ip` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request valid |
| req_ready | output | 1 | Unit idle, request may be taken |
| req_kind | input | 3 | Branch kind code (see R1–R5, R9) |
| req_cs | input | 16 | Current code segment |
| req_ip | input | 16 | Current instruction pointer (start of branch instruction) |
| req_len | input | 4 | Branch instruction length in bytes |
| req_imm | input | 32 | Displacement or segment:offset pointer |
| req_reg | input | 16 | Register operand |
| req_ds | input | 16 | Data segment for the memory-target read |
| mem_rd_valid | output | 1 | Read address valid |
| mem_rd_ready | input | 1 | Memory accepts read address |
| mem_rd_addr | output | 20 | Physical read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data word |
| done | output | 1 | One-cycle result strobe |
| new_cs | output | 16 | Resulting code segment |
| new_ip | output | 16 | Resulting instruction pointer |
| fetch_addr | output | 20 | Physical fetch address of the target |

## Verification
Each request is driven on a falling edge and taken on the next rising edge. For every kind except the memory target, the bench reads the result at the falling edge one cycle later, and checks on the following falling edge that `done` has dropped and the outputs have held. For the memory target, the bench stalls `mem_rd_ready` for 0 to 3 cycles and checks the held address at each stalled falling edge. It then delays the response by 0 to 3 further cycles, confirming `done` stays low throughout, and expects the result one cycle after the response edge. Expected offsets, read addresses and fetch addresses are recomputed in the bench with plain 16- and 20-bit modular arithmetic over sweeps of all short displacements, wide near displacements and edge pointers.

// File: rtl/btu_pkg.sv
package btu_pkg;
  typedef enum logic [2:0] {
    BK_FAR   = 3'd0,
    BK_SHORT = 3'd1,
    BK_NEAR  = 3'd2,
    BK_REG   = 3'd3,
    BK_MEM   = 3'd4
  } br_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2
  } btu_state_e;
endpackage

// File: rtl/btu_phys_addr.sv
module btu_phys_addr #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [PHYS_W-1:0] phys
);
  localparam int SHIFTED_W = SEG_W + SEG_SHIFT;
  localparam int SUM_W     = ((SHIFTED_W > OFF_W) ? SHIFTED_W : OFF_W) + 1;

  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  assign seg_ext = SUM_W'(seg) << SEG_SHIFT;
  assign off_ext = SUM_W'(off);
  assign sum     = seg_ext + off_ext;
  assign phys    = sum[PHYS_W-1:0];
endmodule

// File: rtl/btu_target_calc.sv
module btu_target_calc
  import btu_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int LEN_W   = 4,
  parameter int SHORT_W = 8
) (
  input  logic [2:0]             kind,
  input  logic [SEG_W-1:0]       cur_cs,
  input  logic [OFF_W-1:0]       cur_ip,
  input  logic [LEN_W-1:0]       ins_len,
  input  logic [SEG_W+OFF_W-1:0] imm,
  input  logic [OFF_W-1:0]       reg_val,
  output logic [SEG_W-1:0]       calc_cs,
  output logic [OFF_W-1:0]       calc_ip
);
  localparam int IMM_W = SEG_W + OFF_W;

  logic [OFF_W-1:0] seq_ip;
  logic [OFF_W-1:0] short_disp;
  logic [OFF_W-1:0] near_disp;
  logic [SEG_W-1:0] far_seg;
  logic [OFF_W-1:0] far_off;

  // Address of the instruction that follows the branch.
  assign seq_ip = cur_ip + OFF_W'(ins_len);

  generate
    if (SHORT_W < OFF_W) begin : g_sext
      assign short_disp = {{(OFF_W-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
    end else begin : g_nosext
      assign short_disp = imm[OFF_W-1:0];
    end
  endgenerate

  assign near_disp = imm[OFF_W-1:0];
  assign far_off   = imm[OFF_W-1:0];
  assign far_seg   = imm[IMM_W-1:OFF_W];

  always_comb begin
    calc_cs = cur_cs;
    calc_ip = seq_ip;
    case (kind)
      BK_FAR: begin
        calc_cs = far_seg;
        calc_ip = far_off;
      end
      BK_SHORT: calc_ip = seq_ip + short_disp;
      BK_NEAR:  calc_ip = seq_ip + near_disp;
      BK_REG:   calc_ip = reg_val;
      default:  calc_ip = seq_ip;
    endcase
  end
endmodule

// File: rtl/btu_seq.sv
module btu_seq
  import btu_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int PHYS_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [SEG_W-1:0]  cur_cs,
  input  logic [SEG_W-1:0]  calc_cs,
  input  logic [OFF_W-1:0]  calc_ip,
  input  logic [PHYS_W-1:0] rd_addr_in,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PHYS_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [OFF_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic [SEG_W-1:0]  new_cs,
  output logic [OFF_W-1:0]  new_ip
);
  btu_state_e        state;
  logic [SEG_W-1:0]  hold_cs;
  logic [PHYS_W-1:0] rd_addr_q;
  logic              accept;

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_RD_REQ);
  assign mem_rd_addr  = rd_addr_q;
  assign accept       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hold_cs   <= '0;
      rd_addr_q <= '0;
      done      <= 1'b0;
      new_cs    <= '0;
      new_ip    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (req_kind == BK_MEM) begin
              rd_addr_q <= rd_addr_in;
              hold_cs   <= cur_cs;
              state     <= ST_RD_REQ;
            end else begin
              new_cs <= calc_cs;
              new_ip <= calc_ip;
              done   <= 1'b1;
            end
          end
        end
        ST_RD_REQ: begin
          if (mem_rd_ready) state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            new_cs <= hold_cs;
            new_ip <= mem_rsp_data;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a stalled read keeps its request and address
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R7: a read request only starts from an accepted request
  p_rd_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_valid) |-> $past(req_valid && req_ready));

  // R11: results move only with done
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_cs) && $stable(new_ip)));
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int LEN_W     = 4,
  parameter int SHORT_W   = 8,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_kind,
  input  logic [SEG_W-1:0]       req_cs,
  input  logic [OFF_W-1:0]       req_ip,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [SEG_W+OFF_W-1:0] req_imm,
  input  logic [OFF_W-1:0]       req_reg,
  input  logic [SEG_W-1:0]       req_ds,
  output logic                   mem_rd_valid,
  input  logic                   mem_rd_ready,
  output logic [PHYS_W-1:0]      mem_rd_addr,
  input  logic                   mem_rsp_valid,
  input  logic [OFF_W-1:0]       mem_rsp_data,
  output logic                   done,
  output logic [SEG_W-1:0]       new_cs,
  output logic [OFF_W-1:0]       new_ip,
  output logic [PHYS_W-1:0]      fetch_addr
);
  logic [SEG_W-1:0]  calc_cs;
  logic [OFF_W-1:0]  calc_ip;
  logic [PHYS_W-1:0] rd_addr;

  btu_target_calc #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .SHORT_W(SHORT_W)
  ) u_calc (
    .kind(req_kind), .cur_cs(req_cs), .cur_ip(req_ip), .ins_len(req_len),
    .imm(req_imm), .reg_val(req_reg), .calc_cs(calc_cs), .calc_ip(calc_ip)
  );

  btu_phys_addr #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)
  ) u_rd_phys (
    .seg(req_ds), .off(req_reg), .phys(rd_addr)
  );

  btu_seq #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PHYS_W(PHYS_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .cur_cs(req_cs), .calc_cs(calc_cs), .calc_ip(calc_ip),
    .rd_addr_in(rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .new_cs(new_cs), .new_ip(new_ip)
  );

  btu_phys_addr #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)
  ) u_fetch_phys (
    .seg(new_cs), .off(new_ip), .phys(fetch_addr)
  );

  // R1: far pointer result taken from the immediate
  p_far_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready && req_kind == BK_FAR) && done)
      |-> (new_cs == $past(req_imm[SEG_W+OFF_W-1:OFF_W]) && new_ip == $past(req_imm[OFF_W-1:0])));

  // R4: register target keeps the segment and takes the register
  p_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready && req_kind == BK_REG) && done)
      |-> (new_cs == $past(req_cs) && new_ip == $past(req_reg)));

  // R7: every non-memory request gives done in the next cycle
  p_done_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind != BK_MEM) |=> done);

  // R6: the low nibble of the fetch address is the offset's low nibble
  p_fetch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[SEG_SHIFT-1:0] == new_ip[SEG_SHIFT-1:0]);
endmodule

// File: tb/sim_branch_target_unit.sv
module sim_branch_target_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_kind;
  logic [15:0] req_cs, req_ip, req_reg, req_ds;
  logic [3:0]  req_len;
  logic [31:0] req_imm;
  logic        mem_rd_valid, mem_rd_ready;
  logic [19:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        done;
  logic [15:0] new_cs, new_ip;
  logic [19:0] fetch_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_cs(req_cs), .req_ip(req_ip), .req_len(req_len),
    .req_imm(req_imm), .req_reg(req_reg), .req_ds(req_ds),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .new_cs(new_cs), .new_ip(new_ip), .fetch_addr(fetch_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], 8'hA5};
  endfunction

  task automatic issue(input logic [2:0] k, input logic [15:0] cs, input logic [15:0] ip,
                       input logic [3:0] len, input logic [31:0] imm,
                       input logic [15:0] rg, input logic [15:0] ds);
    chk("R7 ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_kind = k; req_cs = cs; req_ip = ip;
    req_len = len; req_imm = imm; req_reg = rg; req_ds = ds;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_plain(input string tag, input logic [2:0] k, input logic [15:0] cs,
                           input logic [15:0] ip, input logic [3:0] len, input logic [31:0] imm,
                           input logic [15:0] rg, input logic [15:0] exp_cs, input logic [15:0] exp_ip);
    issue(k, cs, ip, len, imm, rg, 16'h0);
    chk({tag, " R7 done"}, {31'b0, done}, 32'd1);
    chk({tag, " cs"}, {16'h0, new_cs}, {16'h0, exp_cs});
    chk({tag, " ip"}, {16'h0, new_ip}, {16'h0, exp_ip});
    chk({tag, " R6 fetch"}, {12'h0, fetch_addr}, {12'h0, phys(exp_cs, exp_ip)});
    @(negedge clk);
    chk({tag, " R11 pulse"}, {31'b0, done}, 32'd0);
    chk({tag, " R11 hold"}, {new_cs, new_ip}, {exp_cs, exp_ip});
  endtask

  task automatic run_mem(input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] rg,
                         input logic [15:0] ds, input int rdy_dly, input int rsp_dly);
    logic [19:0] ea;
    ea = phys(ds, rg);
    issue(3'd4, cs, ip, 4'd2, 32'h0, rg, ds);
    for (int k = 0; k < rdy_dly; k++) begin
      chk("R8 stalled valid", {31'b0, mem_rd_valid}, 32'd1);
      chk("R8 stalled addr", {12'h0, mem_rd_addr}, {12'h0, ea});
      chk("R7 busy not ready", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    chk("R5 read valid", {31'b0, mem_rd_valid}, 32'd1);
    chk("R5 read addr", {12'h0, mem_rd_addr}, {12'h0, ea});
    mem_rd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk("R5 read dropped", {31'b0, mem_rd_valid}, 32'd0);
    for (int k = 0; k < rsp_dly; k++) begin
      chk("R7 no done before data", {31'b0, done}, 32'd0);
      chk("R7 busy waiting", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = mem_word(ea);
    @(posedge clk);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R7 mem done", {31'b0, done}, 32'd1);
    chk("R5 cs kept", {16'h0, new_cs}, {16'h0, cs});
    chk("R5 ip from memory", {16'h0, new_ip}, {16'h0, mem_word(ea)});
    chk("R6 mem fetch", {12'h0, fetch_addr}, {12'h0, phys(cs, mem_word(ea))});
    @(negedge clk);
    chk("R11 mem pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_cs = '0; req_ip = '0;
    req_len = '0; req_imm = '0; req_reg = '0; req_ds = '0;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 done", {31'b0, done}, 32'd0);
    chk("R10 rd_valid", {31'b0, mem_rd_valid}, 32'd0);
    chk("R10 ready", {31'b0, req_ready}, 32'd1);
    chk("R10 cs:ip", {new_cs, new_ip}, 32'h0);
    chk("R10 fetch", {12'h0, fetch_addr}, 32'h0);

    // R1 far pointers, including all-ones for 20-bit wrap
    for (int i = 0; i < 64; i++) begin
      logic [31:0] p;
      p = (i == 63) ? 32'hFFFF_FFFF : {16'(i * 16'h0411), 16'(i * 16'h1C03 + 7)};
      run_plain("R1 far", 3'd0, 16'h1234, 16'h0100, 4'd5, p, 16'h0, p[31:16], p[15:0]);
    end

    // R2 short relative: every displacement, low and wrapping IPs
    for (int d = 0; d < 256; d++) begin
      logic [15:0] sx;
      sx = {{8{d[7]}}, 8'(d)};
      run_plain("R2 short", 3'd1, 16'h2000, 16'h0010, 4'd2, {24'hABCDEF, 8'(d)}, 16'h0,
                16'h2000, 16'h0012 + sx);
      run_plain("R2 short wrap", 3'd1, 16'hF000, 16'hFFF8, 4'd2, {24'h0, 8'(d)}, 16'h0,
                16'hF000, 16'hFFFA + sx);
    end

    // R3 near relative with wrapping sum
    for (int d = 0; d < 128; d++) begin
      logic [15:0] dd;
      dd = 16'(d * 16'h0203 + 16'h8000 * (d % 2));
      run_plain("R3 near", 3'd2, 16'h0F00, 16'hFFFE, 4'd3, {16'h5555, dd}, 16'h0,
                16'h0F00, 16'h0001 + dd);
    end

    // R4 register target
    for (int r = 0; r < 32; r++) begin
      logic [15:0] rv;
      rv = (r == 0) ? 16'h1000 : 16'(r * 16'h0801 + 16'h00FF);
      run_plain("R4 reg", 3'd3, 16'h0ABC, 16'h0440, 4'd2, 32'hDEAD_BEEF, rv, 16'h0ABC, rv);
    end

    // R9 unused codes fall through to next instruction
    for (int k = 5; k < 8; k++)
      run_plain("R9 unused", 3'(k), 16'h3333, 16'hFFFF, 4'd4, 32'h1234_5678, 16'h9999,
                16'h3333, 16'h0003);

    // R5 / R8 memory target with stalls on both halves
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        run_mem(16'h4000 + 16'(a), 16'h0200, 16'(a * 16'h3001 + b * 16'h0123),
                16'hF000 + 16'(b * 16'h0321), a, b);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule